// File: doc/BRIEF.md
# Clock Source Select and Switch Sequencer

This block holds the 32-bit control word that chooses which of up to five clock sources drives the system clock, and it runs the handshake that moves from one source to another. Software places a source code in the selection field and sets the request bit. The sequencer checks the code first. A code that is unused, or one that names the source already in use, clears the request and changes nothing. A valid code starts a wait for the ready flag of that one source. When the flag arrives, the code moves into the read-only current-source field and the request clears. If the flag does not arrive within a set number of cycles, the request clears and the current source stays as it was.

A pulse on the clock-failure input overrides everything else. It forces the current source back to the fast RC source (code 0), sets the sticky failure flag and cancels any request. A write is taken only in a cycle where the unlock input is high. A lock bit, which only reset can clear, freezes the selection field and the request bit. The remaining configuration fields stay writable and have no effect inside this block.

Top module: `clksel_ctrl`

## Requirements
- R1: Reset is synchronous, active low. During reset the register reads 0x00000003 with bit 21 equal to `two_speed_cfg`, and `cur_src` is 0. Bit 0 is the request, bit 1 the secondary enable. One edge after reset releases, bit 0 reads 0, because the reset request names the current source.
- R2: A write with `wr_unlocked` low changes no bit of the register.
- R3: An accepted write with bit 0 = 1 and a selection field (bits 11:8) holding a valid code that differs from the current one starts a switch. Codes: 0 fast RC, 1 PLL, 2 primary, 3 secondary, 4 low-power RC. `switch_busy` is high one edge after the write. The edge after the target's ready is seen, bits 15:12 take the new code and bit 0 clears.
- R4: Writing 0 to bit 0 does not clear a pending request.
- R5: A request whose selection equals the current source clears bit 0 one edge after it is set, without going busy.
- R6: A request that holds a reserved code (5 to 15) clears bit 0 one edge later. The current source and the failure flag (bit 3) are left unchanged.
- R7: If the target's ready never arrives, bit 0 clears TIMEOUT_CYCLES edges after the sequencer goes busy, and the current source is kept.
- R8: A `clk_fail` pulse sets bit 3, forces bits 15:12 to 0, clears bit 0 and ends any switch in progress, all at the next edge.
- R9: Writing 1 to bit 3 sets it and requests a switch to the selection. Bit 3 clears when a valid switch starts. Writing 0 to bit 3 clears it.
- R10: Writing 1 to bit 7 sets the lock, and writing 0 does not clear it. While the lock is set, writes to bits 11:8 and bit 0 (and the request made through bit 3) are ignored. The other fields remain writable.
- R11: These fields read back what was last written: divider bits 26:24, bit 23, bit 21, bit 4 and bit 1. Unused bits (31:27, 22, 20:16, 6:5, 2) and the current-source field ignore writes and read 0 or their own state.
- R12: Only the ready flag of the target source completes a switch. Ready flags of other sources have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_unlocked | input | 1 | High when the system unlock sequence has been performed |
| wr_data | input | 32 | Write data |
| two_speed_cfg | input | 1 | Reset value of bit 21 |
| src_ready | input | NUM_SRC | Per-source ready flags, indexed by source code |
| clk_fail | input | 1 | One-cycle clock-failure event |
| rd_data | output | 32 | Current register contents |
| cur_src | output | 4 | Active source code for the clock mux |
| switch_busy | output | 1 | High while the sequencer waits for a target's ready |

## Verification
The switch path is driven with five kinds of request. The first is a valid new code whose ready is already high, which shows the exact commit edge. The second names the source in use, which separates the redundant clear from a real start. The third is a reserved code, which shows the rejection leaves the current source alone. The fourth is a valid code whose ready stays low while every other ready is high, which tells target selection apart from "any ready" and shows the timeout edge. A failure pulse during a wait, a switch started through the failure bit, and the same writes with the unlock input low or the lock set show that each gate stops exactly the fields it owns.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

   localparam int SEL_W      = 4;
   localparam int DIV_W      = 3;
   localparam int DATA_W     = 32;

   localparam int B_REQ      = 0;
   localparam int B_SECEN    = 1;
   localparam int B_FAIL     = 3;
   localparam int B_SLEEP    = 4;
   localparam int B_LOCK     = 7;
   localparam int B_NEW      = 8;
   localparam int B_CUR      = 12;
   localparam int B_TWOSPD   = 21;
   localparam int B_DEEP     = 23;
   localparam int B_DIV      = 24;

   localparam logic [SEL_W-1:0] FALLBACK_SEL = '0;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_WAIT = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic req_set;
      logic fail_set;
      logic fail_clr;
      logic sel_we;
      logic lock_set;
      logic cfg_we;
   } wr_ctl_t;

endpackage

// File: rtl/clksel_wgate.sv
module clksel_wgate
   import clksel_pkg::*;
(
   input  logic              wr_en,
   input  logic              wr_unlocked,
   input  logic              lock_q,
   input  logic [DATA_W-1:0] wr_data,
   output wr_ctl_t           ctl
);

   logic taken;

   always_comb begin
      taken        = wr_en && wr_unlocked;
      ctl.cfg_we   = taken;
      ctl.sel_we   = taken && !lock_q;
      ctl.lock_set = taken && wr_data[B_LOCK];
      ctl.fail_set = taken && wr_data[B_FAIL];
      ctl.fail_clr = taken && !wr_data[B_FAIL];
      ctl.req_set  = taken && !lock_q && (wr_data[B_REQ] || wr_data[B_FAIL]);
   end

endmodule

// File: rtl/clksel_rdy_sel.sv
module clksel_rdy_sel
   import clksel_pkg::*;
#(
   parameter int NUM_SRC    = 5,
   parameter bit SYNC_READY = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_ready,
   input  logic [SEL_W-1:0]   tgt,
   output logic               tgt_rdy
);

   logic [NUM_SRC-1:0] rdy_v;
   logic [NUM_SRC-1:0] hit;

   generate
      if (SYNC_READY) begin : g_sync
         logic [NUM_SRC-1:0] s1_q;
         logic [NUM_SRC-1:0] s2_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               s1_q <= '0;
               s2_q <= '0;
            end else begin
               s1_q <= src_ready;
               s2_q <= s1_q;
            end
         end
         assign rdy_v = s2_q;
      end else begin : g_direct
         assign rdy_v = src_ready;
      end
   endgenerate

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
         assign hit[g] = rdy_v[g] && (tgt == SEL_W'(g));
      end
   endgenerate

   assign tgt_rdy = |hit;

endmodule

// File: rtl/clksel_seq.sv
module clksel_seq
   import clksel_pkg::*;
#(
   parameter int NUM_SRC        = 5,
   parameter int TIMEOUT_CYCLES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_q,
   input  logic [SEL_W-1:0] new_sel,
   input  logic [SEL_W-1:0] cur_sel,
   input  logic             tgt_rdy,
   input  logic             fail_evt,
   output logic             busy,
   output logic [SEL_W-1:0] tgt,
   output logic             req_clr,
   output logic             start,
   output logic             commit
);

   localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
   localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

   seq_state_e       st_q, st_d;
   logic [TMR_W-1:0] tmr_q, tmr_d;
   logic [SEL_W-1:0] tgt_q, tgt_d;
   logic             code_ok;

   assign code_ok = (new_sel < SEL_W'(NUM_SRC));

   always_comb begin
      st_d    = st_q;
      tmr_d   = tmr_q;
      tgt_d   = tgt_q;
      req_clr = 1'b0;
      start   = 1'b0;
      commit  = 1'b0;
      if (fail_evt) begin
         st_d  = SEQ_IDLE;
         tmr_d = '0;
      end else begin
         unique case (st_q)
            SEQ_IDLE: begin
               if (req_q) begin
                  if (!code_ok || (new_sel == cur_sel)) begin
                     req_clr = 1'b1;
                  end else begin
                     start = 1'b1;
                     st_d  = SEQ_WAIT;
                     tgt_d = new_sel;
                     tmr_d = '0;
                  end
               end
            end
            SEQ_WAIT: begin
               if (tgt_rdy) begin
                  commit  = 1'b1;
                  req_clr = 1'b1;
                  st_d    = SEQ_IDLE;
               end else if (tmr_q == TMR_LAST) begin
                  req_clr = 1'b1;
                  st_d    = SEQ_IDLE;
               end else begin
                  tmr_d = tmr_q + 1'b1;
               end
            end
            default: st_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SEQ_IDLE;
         tmr_q <= '0;
         tgt_q <= FALLBACK_SEL;
      end else begin
         st_q  <= st_d;
         tmr_q <= tmr_d;
         tgt_q <= tgt_d;
      end
   end

   assign busy = (st_q == SEQ_WAIT);
   assign tgt  = tgt_q;

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
   import clksel_pkg::*;
#(
   parameter int NUM_SRC        = 5,
   parameter int TIMEOUT_CYCLES = 64,
   parameter bit SYNC_READY     = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_unlocked,
   input  logic [31:0]        wr_data,
   input  logic               two_speed_cfg,
   input  logic [NUM_SRC-1:0] src_ready,
   input  logic               clk_fail,
   output logic [31:0]        rd_data,
   output logic [3:0]         cur_src,
   output logic               switch_busy
);

   generate
      if (NUM_SRC < 1 || NUM_SRC > (1 << SEL_W)) begin : g_bad_src
         $error("clksel_ctrl: NUM_SRC out of range");
      end
      if (TIMEOUT_CYCLES < 2) begin : g_bad_tmo
         $error("clksel_ctrl: TIMEOUT_CYCLES must be at least 2");
      end
   endgenerate

   wr_ctl_t          ctl;
   logic             req_q, fail_q, lock_q;
   logic             secen_q, sleep_q, twospd_q, deep_q;
   logic [DIV_W-1:0] div_q;
   logic [SEL_W-1:0] new_q, cur_q;
   logic             seq_busy, req_clr, start, commit, tgt_rdy;
   logic [SEL_W-1:0] tgt;

   clksel_wgate u_wgate (
      .wr_en       (wr_en),
      .wr_unlocked (wr_unlocked),
      .lock_q      (lock_q),
      .wr_data     (wr_data),
      .ctl         (ctl)
   );

   clksel_rdy_sel #(
      .NUM_SRC    (NUM_SRC),
      .SYNC_READY (SYNC_READY)
   ) u_rdy (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_ready (src_ready),
      .tgt       (tgt),
      .tgt_rdy   (tgt_rdy)
   );

   clksel_seq #(
      .NUM_SRC        (NUM_SRC),
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_q    (req_q),
      .new_sel  (new_q),
      .cur_sel  (cur_q),
      .tgt_rdy  (tgt_rdy),
      .fail_evt (clk_fail),
      .busy     (seq_busy),
      .tgt      (tgt),
      .req_clr  (req_clr),
      .start    (start),
      .commit   (commit)
   );

   // request bit: failure wins, then a software set, then the sequencer clear
   always_ff @(posedge clk) begin
      if (!rst_n)            req_q <= 1'b1;
      else if (clk_fail)     req_q <= 1'b0;
      else if (ctl.req_set)  req_q <= 1'b1;
      else if (req_clr)      req_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            fail_q <= 1'b0;
      else if (clk_fail)     fail_q <= 1'b1;
      else if (ctl.fail_set) fail_q <= 1'b1;
      else if (start)        fail_q <= 1'b0;
      else if (ctl.fail_clr) fail_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            cur_q <= FALLBACK_SEL;
      else if (clk_fail)     cur_q <= FALLBACK_SEL;
      else if (commit)       cur_q <= tgt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            new_q <= FALLBACK_SEL;
      else if (ctl.sel_we)   new_q <= wr_data[B_NEW +: SEL_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            lock_q <= 1'b0;
      else if (ctl.lock_set) lock_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q    <= '0;
         deep_q   <= 1'b0;
         twospd_q <= two_speed_cfg;
         sleep_q  <= 1'b0;
         secen_q  <= 1'b1;
      end else if (ctl.cfg_we) begin
         div_q    <= wr_data[B_DIV +: DIV_W];
         deep_q   <= wr_data[B_DEEP];
         twospd_q <= wr_data[B_TWOSPD];
         sleep_q  <= wr_data[B_SLEEP];
         secen_q  <= wr_data[B_SECEN];
      end
   end

   always_comb begin
      rd_data                   = '0;
      rd_data[B_DIV +: DIV_W]   = div_q;
      rd_data[B_DEEP]           = deep_q;
      rd_data[B_TWOSPD]         = twospd_q;
      rd_data[B_CUR +: SEL_W]   = cur_q;
      rd_data[B_NEW +: SEL_W]   = new_q;
      rd_data[B_LOCK]           = lock_q;
      rd_data[B_SLEEP]          = sleep_q;
      rd_data[B_FAIL]           = fail_q;
      rd_data[B_SECEN]          = secen_q;
      rd_data[B_REQ]            = req_q;
   end

   assign cur_src     = cur_q;
   assign switch_busy = seq_busy;

endmodule

// File: rtl/clksel_chk.sv
module clksel_chk #(
   parameter int NUM_SRC        = 5,
   parameter int TIMEOUT_CYCLES = 64
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wr_unlocked,
   input logic        clk_fail,
   input logic [31:0] rd_data,
   input logic [3:0]  cur_src,
   input logic        switch_busy
);

   localparam int RUN_W = $clog2(TIMEOUT_CYCLES + 2) + 1;
   localparam logic [31:0] HOLD_MASK = 32'h07A0_0F92;

   logic [RUN_W-1:0] busy_run;
   logic             taken;

   assign taken = wr_en && wr_unlocked;

   always_ff @(posedge clk) begin
      if (!rst_n)                busy_run <= '0;
      else if (!switch_busy)     busy_run <= '0;
      else if (busy_run <= RUN_W'(TIMEOUT_CYCLES)) busy_run <= busy_run + 1'b1;
   end

   // R8
   fail_forces_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_fail |=> (cur_src == 4'd0) && rd_data[3] && !rd_data[0] && !switch_busy);

   // R10
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7] |=> rd_data[7]);

   // R2
   no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |=> $stable(rd_data & HOLD_MASK));

   // R3
   cur_only_on_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!switch_busy && !clk_fail) |=> $stable(cur_src));

   // R3
   cur_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_src < 4'(NUM_SRC));

   // R6
   reserved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[0] && !switch_busy && (rd_data[11:8] >= 4'(NUM_SRC)) && !taken && !clk_fail)
      |=> (!rd_data[0] && !switch_busy));

   // R7
   busy_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= RUN_W'(TIMEOUT_CYCLES));

endmodule

bind clksel_ctrl clksel_chk #(
   .NUM_SRC        (NUM_SRC),
   .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_unlocked (wr_unlocked),
   .clk_fail    (clk_fail),
   .rd_data     (rd_data),
   .cur_src     (cur_src),
   .switch_busy (switch_busy)
);

// File: tb/sim_clksel_ctrl.sv
`timescale 1ns/1ps
module sim_clksel_ctrl;

   localparam int NSRC = 5;
   localparam int TMO  = 16;
   localparam logic [31:0] LO = 32'h0000_FFFF;
   localparam logic [31:0] ALL = 32'hFFFF_FFFF;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic            wr_unlocked = 1'b0;
   logic [31:0]     wr_data = '0;
   logic            two_speed_cfg = 1'b1;
   logic [NSRC-1:0] src_ready = '0;
   logic            clk_fail = 1'b0;
   logic [31:0]     rd_data;
   logic [3:0]      cur_src;
   logic            switch_busy;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int          due;
      logic [31:0] mask;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];

   clksel_ctrl #(
      .NUM_SRC        (NSRC),
      .TIMEOUT_CYCLES (TMO)
   ) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_unlocked   (wr_unlocked),
      .wr_data       (wr_data),
      .two_speed_cfg (two_speed_cfg),
      .src_ready     (src_ready),
      .clk_fail      (clk_fail),
      .rd_data       (rd_data),
      .cur_src       (cur_src),
      .switch_busy   (switch_busy)
   );

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare every expectation that falls due in this cycle
   always @(negedge clk) begin
      if (!done) begin
         for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
               checks++;
               if ((rd_data & sb[i].mask) !== sb[i].exp) begin
                  errors++;
                  $display("FAIL %s: actual %08h expected %08h (cycle %0d)",
                           sb[i].tag, rd_data & sb[i].mask, sb[i].exp, cyc);
               end
               sb.delete(i);
            end else if (sb[i].due < cyc) begin
               checks++;
               errors++;
               $display("FAIL %s: actual missed expected due %0d", sb[i].tag, sb[i].due);
               sb.delete(i);
            end
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 5000 && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual cycle %0d expected end before 5000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic push(input int d, input logic [31:0] m, input logic [31:0] e, input string t);
      item_t it;
      it.due  = cyc + d;
      it.mask = m;
      it.exp  = e & m;
      it.tag  = t;
      sb.push_back(it);
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [31:0] d, input logic unl);
      @(posedge clk);
      #2;
      wr_en       = 1'b1;
      wr_unlocked = unl;
      wr_data     = d;
      @(posedge clk);
      #2;
      wr_en       = 1'b0;
      wr_unlocked = 1'b0;
   endtask

   task automatic pulse_fail();
      @(posedge clk);
      #2;
      clk_fail = 1'b1;
      @(posedge clk);
      #2;
      clk_fail = 1'b0;
   endtask

   initial begin
      settle(2);
      // R1 reset value with two-speed default high
      push(1, ALL, 32'h0020_0003, "R1 reset value");
      settle(2);
      rst_n = 1'b1;
      // R1 R5 reset request names current source and self-clears
      push(1, ALL, 32'h0020_0002, "R1 R5 reset request cleared");
      settle(3);

      // R2 locked-out write
      wr(32'h0000_0201, 1'b0);
      push(0, ALL, 32'h0020_0002, "R2 write without unlock");
      push(2, ALL, 32'h0020_0002, "R2 no switch started");
      settle(3);

      // R11 config fields read back, unused bits and current field ignored
      wr(32'hC7E0_4032, 1'b1);
      push(0, ALL, 32'h07A0_0012, "R11 config readback");
      settle(2);
      wr(32'h0000_0000, 1'b1);
      push(0, ALL, 32'h0000_0000, "R11 config cleared");
      settle(2);

      // R3 valid switch to primary with ready already high
      src_ready = 5'b00100;
      wr(32'h0000_0201, 1'b1);
      push(0, LO, 32'h0000_0201, "R3 request taken");
      push(1, LO, 32'h0000_0201, "R3 waiting");
      push(2, LO, 32'h0000_2200, "R3 committed");
      settle(3);

      // R5 redundant request
      wr(32'h0000_0201, 1'b1);
      push(0, LO, 32'h0000_2201, "R5 redundant set");
      push(1, LO, 32'h0000_2200, "R5 redundant cleared");
      settle(3);

      // R12 R7 R4 target never ready, all others ready
      src_ready = 5'b10111;
      wr(32'h0000_0301, 1'b1);
      push(0, LO, 32'h0000_2301, "R7 request taken");
      push(TMO, LO, 32'h0000_2301, "R12 other readies ignored");
      push(TMO + 1, LO, 32'h0000_2300, "R7 timeout clears request");
      settle(3);
      wr(32'h0000_0300, 1'b1);
      push(0, LO, 32'h0000_2301, "R4 write 0 keeps request");
      settle(TMO + 2);

      // R6 reserved code
      wr(32'h0000_0701, 1'b1);
      push(0, LO, 32'h0000_2701, "R6 reserved request");
      push(1, LO, 32'h0000_2700, "R6 reserved dropped");
      push(3, LO, 32'h0000_2700, "R6 current kept");
      settle(4);

      // R8 failure during a wait
      src_ready = 5'b00000;
      wr(32'h0000_0101, 1'b1);
      push(1, LO, 32'h0000_2101, "R8 waiting for PLL");
      settle(1);
      pulse_fail();
      push(0, LO, 32'h0000_0108, "R8 fallback to RC");
      src_ready = 5'b00010;
      push(3, LO, 32'h0000_0108, "R8 wait aborted");
      settle(4);

      // R9 software clears fail flag, then starts a switch through it
      wr(32'h0000_0100, 1'b1);
      push(0, LO, 32'h0000_0100, "R9 fail flag cleared");
      settle(2);
      wr(32'h0000_0109, 1'b1);
      push(0, LO, 32'h0000_0109, "R9 fail write requests");
      push(1, LO, 32'h0000_0101, "R9 fail cleared on start");
      push(2, LO, 32'h0000_1100, "R9 switch committed");
      settle(3);

      // R10 lock
      wr(32'h0000_0280, 1'b1);
      push(0, LO, 32'h0000_1280, "R10 lock set");
      settle(2);
      src_ready = 5'b01000;
      wr(32'h0000_0301, 1'b1);
      push(0, LO, 32'h0000_1280, "R10 selection blocked");
      push(2, LO, 32'h0000_1280, "R10 no switch");
      settle(3);
      wr(32'h0000_0010, 1'b1);
      push(0, LO, 32'h0000_1290, "R10 lock kept, other field writable");
      settle(2);

      // R1 reset clears lock, default follows configuration input
      rst_n = 1'b0;
      push(1, ALL, 32'h0020_0003, "R1 reset clears lock");
      settle(2);
      two_speed_cfg = 1'b0;
      push(1, ALL, 32'h0000_0003, "R1 two-speed default low");
      settle(2);
      rst_n = 1'b1;
      push(1, ALL, 32'h0000_0002, "R1 after release");
      settle(3);

      done = 1'b1;
      if (sb.size() != 0) begin
         checks += sb.size();
         errors += sb.size();
         $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule